// File: doc/BRIEF.md
# I2C Single-Master Byte Engine

This block turns simple commands from a local controller into I2C bus waveforms for a single bus master. The controller can ask for four things. The first is a START condition, which also serves as a repeated START when the bus is already claimed. The second is a STOP condition. The third writes one byte and records the slave's acknowledge. The fourth reads one byte and returns either an acknowledge or a not-acknowledge to the slave. Each command is handed over on a valid/ready handshake. The engine is busy until the bus step is complete. The received byte and the slave's acknowledge level remain on the result outputs until a later command replaces them.

The engine never drives a line high. It pulls SCL or SDA low through an active-high output-enable, and an external pull-up releases the line. The SCL and SDA pad inputs pass through a synchronizer. A half-period count, `HALF_DIV` clock cycles, sets the bit timing. The default is 1250, which gives a 100 kbit/s bus from a 250 MHz clock. `HALF_DIV` must be at least 4.

The time an SCL high phase lasts is counted only after the engine observes SCL high on the synchronized input. A slave that holds SCL low therefore stalls the engine. A byte command leaves SCL held low, so the controller can follow it with another byte, a repeated START or a STOP.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, both output-enables are low, `busy` is low, `cmd_ready` is high, and `rsp_data` and `rsp_nack` are zero.
- R2: Command code 0 (START) pulls SDA low while SCL is high. It then pulls SCL low and returns to ready with both lines held low.
- R3: Command code 1 (STOP) raises SDA while SCL is high. It returns to ready with both lines released.
- R4: Command code 2 (write) shifts `cmd_data` onto SDA most significant bit first, using eight SCL pulses.
- R5: On the ninth SCL pulse of a write, the engine releases SDA. `rsp_nack` then holds the sampled SDA level: 0 means the slave acknowledged and 1 means it did not.
- R6: Command code 3 (read) releases SDA for eight SCL pulses. It returns the sampled bits in `rsp_data`, with the first bit received in the most significant position.
- R7: On the ninth SCL pulse of a read, the engine holds SDA low when `cmd_nack` was 0 and releases it when `cmd_nack` was 1.
- R8: Inside a byte command, SDA changes only while SCL is low.
- R9: Each SCL low phase and each SCL high phase inside a byte lasts at least `HALF_DIV` clocks. The high phase is timed from the moment SCL is seen high, so a slave holding SCL low delays the engine.
- R10: A START issued after a byte first releases SDA with SCL low, then releases SCL, and then pulls SDA low. No STOP condition appears on the bus.
- R11: A command is taken only on a cycle with both `cmd_valid` and `cmd_ready` high. A `cmd_valid` pulse while `busy` is high is dropped, and no bus activity follows from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle and able to take a command |
| cmd_op | input | 2 | 0 START, 1 STOP, 2 write byte, 3 read byte |
| cmd_data | input | DATA_W | Byte to write |
| cmd_nack | input | 1 | For a read: 1 releases SDA on the ninth pulse (NACK), 0 holds it low (ACK) |
| rsp_data | output | DATA_W | Last byte read |
| rsp_nack | output | 1 | SDA level sampled on the ninth pulse of the last write |
| busy | output | 1 | A command is in progress |
| scl_i | input | 1 | SCL pad input |
| sda_i | input | 1 | SDA pad input |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The bench models a slave on a wired-AND bus. That slave acknowledges or refuses bytes, supplies read data, and optionally holds SCL low for longer than a whole half period. An engine that timed the high phase from its own release would then produce high pulses shorter than `HALF_DIV`, or none at all. The bench counts every SDA edge that occurs while SCL is high. A data bit that changes too late shows up as a spurious START or STOP inside a byte. A repeated START that raised SCL before SDA would show up as a STOP. The bench compares the ninth-pulse SDA level with the chosen ACK or NACK, which exposes an engine that drives SDA during the slave's acknowledge. A command offered while the engine is busy must leave both the bus and `busy` untouched.

// File: rtl/i2c_bm_pkg.sv
`timescale 1ns/1ps
package i2c_bm_pkg;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_STOP  = 2'd1,
        OP_WRITE = 2'd2,
        OP_READ  = 2'd3
    } op_e;

    // ST_IDLE must stay first: the register reset relies on its zero encoding.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_S_REL_SDA,
        ST_S_REL_SCL,
        ST_S_PULL_SDA,
        ST_S_PULL_SCL,
        ST_P_PULL,
        ST_P_REL_SCL,
        ST_P_REL_SDA,
        ST_BIT_LO,
        ST_BIT_HI,
        ST_TAIL
    } state_e;

endpackage

// File: rtl/i2c_bm_sync.sv
`timescale 1ns/1ps
module i2c_bm_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] pipe_d;
    logic [STAGES-1:0][WIDTH-1:0] pipe_q;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            assign pipe_d[s] = d;
        end else begin : g_next
            assign pipe_d[s] = pipe_q[s-1];
        end
    end

    // Reset to released lines, which is the idle bus level.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= pipe_d;
    end

    assign q = pipe_q[STAGES-1];

endmodule

// File: rtl/i2c_bm_timer.sv
`timescale 1ns/1ps
module i2c_bm_timer #(
    parameter int HALF_DIV = 1250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic at_mid,
    output logic at_end
);

    localparam int CW = $clog2(HALF_DIV + 1);
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);
    localparam logic [CW-1:0] MID  = CW'(HALF_DIV / 2);

    logic [CW-1:0] cnt_d, cnt_q;

    assign at_end = en && (cnt_q == LAST);
    assign at_mid = en && (cnt_q == MID);

    always_comb begin
        cnt_d = cnt_q;
        if (clr)                 cnt_d = '0;
        else if (en && !at_end)  cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/i2c_byte_master.sv
`timescale 1ns/1ps
module i2c_byte_master
    import i2c_bm_pkg::*;
#(
    parameter int HALF_DIV    = 1250,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              cmd_nack,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_nack,
    output logic              busy,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe
);

    localparam int BIT_CW = $clog2(DATA_W + 1);
    localparam logic [BIT_CW-1:0] ACK_SLOT = BIT_CW'(DATA_W);

    typedef struct packed {
        state_e              state;
        op_e                 op;
        logic [BIT_CW-1:0]   bit_idx;
        logic [DATA_W-1:0]   shreg;
        logic [DATA_W-1:0]   rx;
        logic                nack_sel;
        logic                slv_nack;
        logic                scl_oe;
        logic                sda_oe;
    } regs_t;

    regs_t r_d, r_q;

    logic [1:0] pads_s;
    logic       scl_s, sda_s;
    logic       tmr_clr, tmr_en, tmr_mid, tmr_end;
    logic       bit_low;
    state_e     cur_state;
    op_e        cur_op;
    logic [BIT_CW-1:0] cur_bit;

    i2c_bm_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_i, sda_i}),
        .q     (pads_s)
    );

    assign scl_s = pads_s[1];
    assign sda_s = pads_s[0];

    i2c_bm_timer #(
        .HALF_DIV (HALF_DIV)
    ) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (tmr_clr),
        .en     (tmr_en),
        .at_mid (tmr_mid),
        .at_end (tmr_end)
    );

    assign cur_state = r_q.state;
    assign cur_op    = r_q.op;
    assign cur_bit   = r_q.bit_idx;

    // Level the engine puts on SDA for the current bit slot (1 = pull low).
    always_comb begin
        if (cur_bit == ACK_SLOT)
            bit_low = (cur_op == OP_READ) ? ~r_q.nack_sel : 1'b0;
        else
            bit_low = (cur_op == OP_WRITE) ? ~r_q.shreg[DATA_W-1] : 1'b0;
    end

    always_comb begin
        r_d     = r_q;
        tmr_clr = 1'b0;
        tmr_en  = 1'b0;
        unique case (cur_state)
            ST_IDLE: begin
                if (cmd_valid) begin
                    r_d.op       = op_e'(cmd_op);
                    r_d.shreg    = cmd_data;
                    r_d.nack_sel = cmd_nack;
                    r_d.bit_idx  = '0;
                    tmr_clr      = 1'b1;
                    unique case (op_e'(cmd_op))
                        OP_START: r_d.state = ST_S_REL_SDA;
                        OP_STOP:  r_d.state = ST_P_PULL;
                        default:  r_d.state = ST_BIT_LO;
                    endcase
                end
            end
            // START / repeated START: release SDA with SCL left as it is.
            ST_S_REL_SDA: begin
                r_d.sda_oe = 1'b0;
                tmr_en     = 1'b1;
                if (tmr_end) begin
                    r_d.state = ST_S_REL_SCL;
                    tmr_clr   = 1'b1;
                end
            end
            ST_S_REL_SCL: begin
                r_d.scl_oe = 1'b0;
                tmr_en     = scl_s;
                if (tmr_end) begin
                    r_d.state = ST_S_PULL_SDA;
                    tmr_clr   = 1'b1;
                end
            end
            ST_S_PULL_SDA: begin
                r_d.sda_oe = 1'b1;
                tmr_en     = 1'b1;
                if (tmr_end) begin
                    r_d.state = ST_S_PULL_SCL;
                    tmr_clr   = 1'b1;
                end
            end
            ST_S_PULL_SCL: begin
                r_d.scl_oe = 1'b1;
                tmr_en     = 1'b1;
                if (tmr_end) begin
                    r_d.state = ST_IDLE;
                    tmr_clr   = 1'b1;
                end
            end
            // STOP: make sure SCL is low before SDA is pulled low.
            ST_P_PULL: begin
                r_d.scl_oe = 1'b1;
                r_d.sda_oe = r_q.scl_oe ? 1'b1 : r_q.sda_oe;
                tmr_en     = 1'b1;
                if (tmr_end) begin
                    r_d.state = ST_P_REL_SCL;
                    tmr_clr   = 1'b1;
                end
            end
            ST_P_REL_SCL: begin
                r_d.scl_oe = 1'b0;
                tmr_en     = scl_s;
                if (tmr_end) begin
                    r_d.state = ST_P_REL_SDA;
                    tmr_clr   = 1'b1;
                end
            end
            ST_P_REL_SDA: begin
                r_d.sda_oe = 1'b0;
                tmr_en     = 1'b1;
                if (tmr_end) begin
                    r_d.state = ST_IDLE;
                    tmr_clr   = 1'b1;
                end
            end
            // Bit slot, low phase: SDA moves only once SCL is already held low.
            ST_BIT_LO: begin
                r_d.scl_oe = 1'b1;
                if (r_q.scl_oe) r_d.sda_oe = bit_low;
                tmr_en = 1'b1;
                if (tmr_end) begin
                    r_d.state = ST_BIT_HI;
                    tmr_clr   = 1'b1;
                end
            end
            // Bit slot, high phase: timed only while SCL is seen high.
            ST_BIT_HI: begin
                r_d.scl_oe = 1'b0;
                tmr_en     = scl_s;
                if (tmr_mid) begin
                    if (cur_bit == ACK_SLOT) begin
                        if (cur_op == OP_WRITE) r_d.slv_nack = sda_s;
                        else                    r_d.rx       = r_q.shreg;
                    end else begin
                        r_d.shreg = {r_q.shreg[DATA_W-2:0], sda_s};
                    end
                end
                if (tmr_end) begin
                    r_d.scl_oe = 1'b1;
                    tmr_clr    = 1'b1;
                    if (cur_bit == ACK_SLOT) begin
                        r_d.state = ST_TAIL;
                    end else begin
                        r_d.bit_idx = cur_bit + BIT_CW'(1);
                        r_d.state   = ST_BIT_LO;
                    end
                end
            end
            ST_TAIL: begin
                r_d.scl_oe = 1'b1;
                if (r_q.scl_oe) r_d.sda_oe = 1'b0;
                tmr_en = 1'b1;
                if (tmr_end) begin
                    r_d.state = ST_IDLE;
                    tmr_clr   = 1'b1;
                end
            end
            default: begin
                r_d.state = ST_IDLE;
                tmr_clr   = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cmd_ready = (cur_state == ST_IDLE);
    assign busy      = (cur_state != ST_IDLE);
    assign rsp_data  = r_q.rx;
    assign rsp_nack  = r_q.slv_nack;
    assign scl_oe    = r_q.scl_oe;
    assign sda_oe    = r_q.sda_oe;

endmodule

// File: rtl/i2c_byte_master_sva.sv
`timescale 1ns/1ps
module i2c_byte_master_sva
    import i2c_bm_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int BIT_CW = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              busy,
    input logic              scl_oe,
    input logic              sda_oe,
    input logic              scl_s,
    input state_e            state,
    input op_e               op,
    input logic [BIT_CW-1:0] bit_idx
);

    // R11: a handshake always starts a command
    p_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready |=> busy);

    // R9: no progress out of a high phase while SCL is seen low
    p_hold_stretch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BIT_HI) && !scl_s |=> (state == ST_BIT_HI));

    // R5: SDA left to the slave on the write acknowledge pulse
    p_ack_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BIT_HI) && (op == OP_WRITE) && (int'(bit_idx) == DATA_W) |-> !sda_oe);

    // R6: SDA left to the slave on read data pulses
    p_read_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BIT_HI) && (op == OP_READ) && (int'(bit_idx) < DATA_W) |-> !sda_oe);

    // R8: inside a byte, SDA moves only with SCL held low
    p_sda_when_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) inside {ST_BIT_LO, ST_BIT_HI, ST_TAIL}) && !$stable(sda_oe)
        |-> $past(scl_oe) && scl_oe);

    // R3: STOP finishes with both lines released
    p_stop_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) && (op == OP_STOP) |-> !scl_oe && !sda_oe);

    // R2: START finishes with both lines held low
    p_start_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) && (op == OP_START) |-> scl_oe && sda_oe);

endmodule

bind i2c_byte_master i2c_byte_master_sva #(
    .DATA_W (DATA_W),
    .BIT_CW (BIT_CW)
) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .busy      (busy),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .scl_s     (scl_s),
    .state     (cur_state),
    .op        (cur_op),
    .bit_idx   (cur_bit)
);

// File: tb/i2c_byte_master_tb.sv
`timescale 1ns/1ps
module i2c_byte_master_tb;
    import i2c_bm_pkg::*;

    localparam int HALF = 8;
    localparam int DW   = 8;
    localparam int WATCHDOG = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [1:0]    cmd_op = 2'd0;
    logic [DW-1:0] cmd_data = '0;
    logic          cmd_nack = 1'b0;
    logic [DW-1:0] rsp_data;
    logic          rsp_nack;
    logic          busy;
    logic          scl_oe, sda_oe;

    logic slv_scl_hold = 1'b0;
    logic slv_sda_low  = 1'b0;
    logic scl_bus, sda_bus;
    assign scl_bus = !(scl_oe || slv_scl_hold);
    assign sda_bus = !(sda_oe || slv_sda_low);

    i2c_byte_master #(
        .HALF_DIV (HALF),
        .DATA_W   (DW)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_op    (cmd_op),
        .cmd_data  (cmd_data),
        .cmd_nack  (cmd_nack),
        .rsp_data  (rsp_data),
        .rsp_nack  (rsp_nack),
        .busy      (busy),
        .scl_i     (scl_bus),
        .sda_i     (sda_bus),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe)
    );

    int tests = 0;
    int fails = 0;
    int cyc   = 0;
    bit mon_en  = 1'b0;
    bit in_byte = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected values derived from the requirements
    function automatic int exp_ninth_write(input bit slave_acks);
        return slave_acks ? 0 : 1;
    endfunction
    function automatic int exp_ninth_read(input bit master_nack);
        return master_nack ? 1 : 0;
    endfunction

    // Bus condition monitors
    int start_cnt = 0, stop_cnt = 0, glitch_cnt = 0;
    always @(negedge sda_bus) if (mon_en && scl_bus === 1'b1) begin
        start_cnt++;
        if (in_byte) glitch_cnt++;
    end
    always @(posedge sda_bus) if (mon_en && scl_bus === 1'b1) begin
        stop_cnt++;
        if (in_byte) glitch_cnt++;
    end

    // SCL phase length measurement inside bytes
    int  hi_run = 0, lo_run = 0, min_hi = 1000000, min_lo = 1000000;
    bit  hi_ok = 1'b0, lo_ok = 1'b0;
    logic prev_scl = 1'b1;
    always @(negedge clk) if (mon_en) begin
        if (scl_bus) begin
            if (!prev_scl) begin
                if (lo_ok && in_byte && lo_run < min_lo) min_lo = lo_run;
                hi_run = 1; hi_ok = 1'b1;
            end else hi_run++;
        end else begin
            if (prev_scl) begin
                if (hi_ok && in_byte && hi_run < min_hi) min_hi = hi_run;
                lo_run = 1; lo_ok = 1'b1;
            end else lo_run++;
        end
        prev_scl = scl_bus;
    end

    // Slave model
    int          rise_cnt = 0;
    int          stretch_n = 0;
    bit          slv_is_read = 1'b0;
    bit          slv_ack = 1'b1;
    logic [7:0]  slv_tx = '0;
    logic [7:0]  slv_rx = '0;
    logic        ninth = 1'b1;

    always @(posedge scl_bus) if (in_byte) begin
        if (rise_cnt < 8)       slv_rx = {slv_rx[6:0], sda_bus};
        else if (rise_cnt == 8) ninth  = sda_bus;
        rise_cnt++;
    end

    always @(negedge scl_bus) if (in_byte) begin
        if (!slv_is_read) begin
            if (rise_cnt == 8)      slv_sda_low = slv_ack;
            else if (rise_cnt == 9) slv_sda_low = 1'b0;
        end else begin
            if (rise_cnt >= 1 && rise_cnt < 8) slv_sda_low = !slv_tx[7 - rise_cnt];
            else if (rise_cnt == 8)            slv_sda_low = 1'b0;
        end
    end

    always @(negedge scl_bus) if (in_byte && stretch_n > 0) begin
        slv_scl_hold = 1'b1;
        repeat (stretch_n) @(negedge clk);
        slv_scl_hold = 1'b0;
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            tests++;
            fails++;
            $display("FAIL watchdog R1..: actual=%0d cycles expected<%0d", cyc, WATCHDOG);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic send_cmd(input op_e op, input logic [7:0] data, input bit nack);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_data  = data;
        cmd_nack  = nack;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        while (slv_scl_hold) @(negedge clk);
    endtask

    task automatic do_start();
        int s0, p0;
        s0 = start_cnt; p0 = stop_cnt;
        send_cmd(OP_START, 8'h00, 1'b0);
        wait_idle();
        chk(start_cnt == s0 + 1, "R2 start count", start_cnt, s0 + 1);
        chk(!scl_bus && !sda_bus, "R2 lines held low", {scl_bus, sda_bus}, 0);
        chk(stop_cnt == p0, "R10 no stop in start", stop_cnt, p0);
    endtask

    task automatic do_stop();
        int p0;
        p0 = stop_cnt;
        send_cmd(OP_STOP, 8'h00, 1'b0);
        wait_idle();
        chk(stop_cnt == p0 + 1, "R3 stop count", stop_cnt, p0 + 1);
        chk(scl_bus && sda_bus && !busy, "R3 lines released", {scl_bus, sda_bus, busy}, 6);
    endtask

    task automatic do_write(input logic [7:0] data, input bit ack, input bit intrude);
        int p0, s0;
        rise_cnt = 0; slv_is_read = 1'b0; slv_ack = ack; slv_sda_low = 1'b0;
        in_byte = 1'b1;
        send_cmd(OP_WRITE, data, 1'b0);
        if (intrude) begin
            repeat (30) @(negedge clk);
            cmd_valid = 1'b1; cmd_op = OP_STOP;
            @(negedge clk);
            cmd_valid = 1'b0;
        end
        wait_idle();
        in_byte = 1'b0;
        chk(slv_rx == data, "R4 byte seen by slave", slv_rx, data);
        chk(int'(rsp_nack) == exp_ninth_write(ack), "R5 rsp_nack", rsp_nack, exp_ninth_write(ack));
        chk(int'(ninth) == exp_ninth_write(ack), "R5 ninth-pulse SDA", ninth, exp_ninth_write(ack));
        if (intrude) begin
            p0 = stop_cnt; s0 = start_cnt;
            repeat (4 * HALF) @(negedge clk);
            chk(!busy && !scl_bus, "R11 dropped command", {busy, scl_bus}, 0);
            chk(stop_cnt == p0 && start_cnt == s0, "R11 no bus activity", stop_cnt - p0, 0);
        end
    endtask

    task automatic do_read(input logic [7:0] data, input bit mnack);
        rise_cnt = 0; slv_is_read = 1'b1; slv_tx = data;
        slv_sda_low = !data[7];
        in_byte = 1'b1;
        send_cmd(OP_READ, 8'h00, mnack);
        wait_idle();
        in_byte = 1'b0;
        slv_sda_low = 1'b0;
        chk(rsp_data == data, "R6 rsp_data", rsp_data, data);
        chk(int'(ninth) == exp_ninth_read(mnack), "R7 master ack level", ninth, exp_ninth_read(mnack));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        mon_en = 1'b1;
        // R1 reset state
        chk(!scl_oe && !sda_oe, "R1 oe after reset", {scl_oe, sda_oe}, 0);
        chk(!busy && cmd_ready, "R1 busy/ready", {busy, cmd_ready}, 1);
        chk(rsp_data == 0 && rsp_nack == 0, "R1 results zero", rsp_data, 0);

        // Directed sequence
        do_start();
        do_write(8'hA5, 1'b1, 1'b0);
        do_write(8'h3C, 1'b0, 1'b0);
        do_start();                       // R10 repeated START
        do_read(8'h96, 1'b0);
        do_read(8'h5A, 1'b1);
        do_read(8'h00, 1'b1);
        do_write(8'hFF, 1'b1, 1'b0);
        stretch_n = 20;                   // R9 slave holds SCL beyond a half period
        do_write(8'h81, 1'b1, 1'b0);
        do_read(8'h7E, 1'b1);
        stretch_n = 0;
        do_write(8'h42, 1'b1, 1'b1);      // R11 command offered while busy
        do_stop();

        // Random transactions
        for (int t = 0; t < 10; t++) begin
            int nb;
            do_start();
            nb = 1 + int'($urandom % 4);
            for (int b = 0; b < nb; b++) begin
                logic [7:0] v;
                v = 8'($urandom);
                stretch_n = ($urandom % 2) ? 3 + int'($urandom % 13) : 0;
                if ($urandom % 2) do_read(v, 1'($urandom));
                else              do_write(v, 1'($urandom), 1'b0);
                if (($urandom % 4) == 0) do_start();
            end
            stretch_n = 0;
            do_stop();
        end

        chk(glitch_cnt == 0, "R8 SDA edges with SCL high inside bytes", glitch_cnt, 0);
        chk(min_hi >= HALF, "R9 shortest SCL high", min_hi, HALF);
        chk(min_lo >= HALF, "R9 shortest SCL low", min_lo, HALF);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule